// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests that arrive at any time from a set of I/O sources. It turns them into one interrupt line and a source vector for a processor. Each request input is brought into the clock domain by a two-flop synchroniser. A rising edge on it sets a latched pending bit, and that bit holds until software or an acknowledge removes it. A processor can find the source in two ways. It can read the cause register, which holds all pending bits. It can also use the vector output, which gives the index of the winning source so that each device has its own handler.

Each source has a configurable urgency level. The controller keeps a stack of the levels currently being serviced. An acknowledge pushes the level of the vectored source onto the stack. A write to the end-of-service register pops it. The interrupt line is raised only when the best unmasked pending level is strictly above the level on top of the stack. A more urgent device can therefore interrupt a handler that is still running, while an equal or less urgent one waits.

A small state machine owns the interrupt line. In ST_IDLE the line is low. IDLE_TO_RAISE is taken when an eligible request exists. In ST_RAISE the line is high and the vector follows the current winner. RAISE_TO_IDLE is taken either on an acknowledge or when eligibility is lost through a clear, a mask or a pop. RAISE_HOLD keeps ST_RAISE while the request stays eligible.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, irq is low, the cause register (address 0) reads 0, the mask register (address 1) reads all ones, the level register (address 2) reads 0 and the in-service level (address 3) reads 0.
- R2: A rising edge on req_async[i] sets cause bit i no later than the third rising clock edge after it. The bit stays set after the input falls.
- R3: A write to address 0 clears each cause bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R4: Mask bit i at address 1, with 1 meaning blocked, keeps source i from raising irq. Its cause bit can still be read, and clearing the mask lets the request through.
- R5: Source i's level is held in bits [2i+1:2i] of address 2. Among unmasked pending sources the highest level wins, and irq_vec carries the winner's index.
- R6: When pending unmasked sources share the top level, the lowest index wins.
- R7: A source at level 0 never raises irq.
- R8: irq is high only while the winning level is strictly greater than the in-service level. The in-service level is 0 when the stack is empty. An acknowledge taken while irq is high clears the vectored source's cause bit and makes its level the in-service level.
- R9: While a handler is in service, a pending source of higher level raises irq again. A source of equal or lower level does not.
- R10: Any write to address 3 pops the in-service stack and restores the previous level. A pop on an empty stack is ignored. A waiting request whose level is now above the restored level raises irq.
- R11: irq is registered. It is high on the fourth rising edge after a request rises, one edge after the cause bit is set, and it falls on the edge that takes the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_async | input | N_SRC | Asynchronous request per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 cause, 1 mask, 2 levels, 3 end of service |
| wr_data | input | N_SRC*PW | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | N_SRC*PW | Combinational read data |
| irq | output | 1 | Interrupt line to the processor |
| irq_vec | output | log2(N_SRC) | Index of the source being presented |
| irq_ack | input | 1 | Processor takes the presented interrupt |

## Verification
If the in-service stack held a wrong level, the fault would show as a missing or extra irq on the first nested request after the error. The address-3 read would also differ at once. If a pending bit were lost or stuck, the cause register would read wrong one cycle after the offending edge, write or acknowledge. The vector would name the wrong source on the next presentation. Errors in the priority or tie ordering appear as soon as two sources are pending together, because the vector is compared on every acknowledge against the order worked out from the configured levels.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RAISE = 1'b1
    } irq_state_e;

    localparam logic [1:0] ADDR_CAUSE = 2'd0;
    localparam logic [1:0] ADDR_MASK  = 2'd1;
    localparam logic [1:0] ADDR_LEVEL = 2'd2;
    localparam logic [1:0] ADDR_EOS   = 2'd3;
endpackage

// File: rtl/nirq_sync.sv
module nirq_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_async,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[1:0], req_async[g]};
        end
        assign rise[g] = sh[1] & ~sh[2];
    end
endmodule

// File: rtl/nirq_resolve.sv
module nirq_resolve #(
    parameter int N   = 8,
    parameter int PW  = 2,
    parameter int IDW = 3
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] lvl_flat,
    output logic            found,
    output logic [IDW-1:0]  win_idx,
    output logic [PW-1:0]   win_lvl
);
    // Strict compare keeps the earliest index on ties and skips level 0.
    always_comb begin
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (lvl_flat[i*PW +: PW] > win_lvl)) begin
                win_lvl = lvl_flat[i*PW +: PW];
                win_idx = IDW'(i);
            end
        end
        found = (win_lvl != '0);
    end
endmodule

// File: rtl/nirq_stack.sv
module nirq_stack #(
    parameter int PW    = 2,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_lvl,
    input  logic          pop,
    output logic [PW-1:0] top_lvl
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IW  = $clog2(DEPTH);

    logic [PW-1:0]  mem [DEPTH];
    logic [SPW-1:0] sp;
    logic           do_pop;

    assign do_pop = pop && (sp != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push && !do_pop) begin
            sp <= sp + 1'b1;
        end else if (!push && do_pop) begin
            sp <= sp - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            if (do_pop) mem[IW'(sp - 1'b1)] <= push_lvl;
            else        mem[IW'(sp)]        <= push_lvl;
        end
    end

    assign top_lvl = (sp == '0) ? '0 : mem[IW'(sp - 1'b1)];

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !do_pop) |-> (sp < SPW'(DEPTH))) else $error("stack overflow"); // R8
    AST_PUSH_BECOMES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top_lvl == $past(push_lvl))) else $error("push lost"); // R8
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nirq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int PW    = 2,
    localparam int IDW   = $clog2(N_SRC),
    localparam int DEPTH = 1 << PW,
    localparam int RW    = N_SRC * PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_async,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [RW-1:0]    wr_data,
    input  logic [1:0]       rd_addr,
    output logic [RW-1:0]    rd_data,
    output logic             irq,
    output logic [IDW-1:0]   irq_vec,
    input  logic             irq_ack
);
    logic [N_SRC-1:0] rise, pend, mask, cand, clr;
    logic [RW-1:0]    lvl_cfg;
    logic             found, eligible, take, pop;
    logic [IDW-1:0]   win_idx, vec_q;
    logic [PW-1:0]    win_lvl, lvl_q, top_lvl;
    irq_state_e       state, state_nx;

    nirq_sync #(.N(N_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_async(req_async), .rise(rise)
    );

    assign cand = pend & ~mask;

    nirq_resolve #(.N(N_SRC), .PW(PW), .IDW(IDW)) u_resolve (
        .cand(cand), .lvl_flat(lvl_cfg), .found(found),
        .win_idx(win_idx), .win_lvl(win_lvl)
    );

    assign take = irq_ack && (state == ST_RAISE);
    assign pop  = wr_en && (wr_addr == ADDR_EOS);

    nirq_stack #(.PW(PW), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .push_lvl(lvl_q),
        .pop(pop), .top_lvl(top_lvl)
    );

    assign eligible = found && (win_lvl > top_lvl);

    // Pending, mask and level registers.
    always_comb begin
        clr = '0;
        if (wr_en && (wr_addr == ADDR_CAUSE)) clr = wr_data[N_SRC-1:0];
        if (take) clr = clr | (N_SRC'(1) << vec_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            mask    <= '1;
            lvl_cfg <= '0;
        end else begin
            pend <= (pend & ~clr) | rise;
            if (wr_en && (wr_addr == ADDR_MASK))  mask    <= wr_data[N_SRC-1:0];
            if (wr_en && (wr_addr == ADDR_LEVEL)) lvl_cfg <= wr_data;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (eligible) state_nx = ST_RAISE;          // IDLE_TO_RAISE
            ST_RAISE: if (take || !eligible) state_nx = ST_IDLE;  // RAISE_TO_IDLE
        endcase
    end

    // Output process: vector and level follow the winner while raised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            lvl_q <= '0;
        end else if (state_nx == ST_RAISE) begin
            vec_q <= win_idx;
            lvl_q <= win_lvl;
        end
    end

    assign irq     = (state == ST_RAISE);
    assign irq_vec = vec_q;

    always_comb begin
        case (rd_addr)
            ADDR_CAUSE: rd_data = RW'(pend);
            ADDR_MASK:  rd_data = RW'(mask);
            ADDR_LEVEL: rd_data = lvl_cfg;
            default:    rd_data = RW'(top_lvl);
        endcase
    end

    AST_IRQ_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (lvl_q > top_lvl)) else $error("irq at or below service level"); // R8
    AST_TAKE_CLEARS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rise[vec_q]) |=> !pend[$past(vec_q)]) else $error("ack left pending"); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CAUSE) |=>
        ((pend & $past(wr_data[N_SRC-1:0]) & ~$past(rise)) == '0)) else $error("w1c failed"); // R3
    AST_WINNER_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[win_idx]) else $error("winner not candidate"); // R4
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
    localparam int N  = 8;
    localparam int PW = 2;
    localparam int RW = N * PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_async = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [RW-1:0] rd_data;
    logic          irq;
    logic [2:0]    irq_vec;
    logic          irq_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int    exp_q[$];
    string tag_q[$];

    nest_irq_ctrl #(.N_SRC(N), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .req_async(req_async), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    always #10 clk = ~clk;

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wr(logic [1:0] a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = RW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, int exp);
        @(negedge clk);
        rd_addr = a;
        #1 check_eq(tag, int'(rd_data), exp);
    endtask

    task automatic irq_chk(string tag, int exp);
        @(negedge clk);
        #2 check_eq(tag, int'(irq), exp);
    endtask

    task automatic raise(int bits);
        @(negedge clk);
        req_async = req_async | N'(bits);
    endtask

    task automatic drop_all();
        @(negedge clk);
        req_async = '0;
        repeat (4) @(posedge clk);
    endtask

    task automatic expect_vec(int v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(posedge clk);
        check_eq(tag, exp_q.size(), 0);
        repeat (3) @(posedge clk);
    endtask

    // Monitor: pops the expected vector when irq is seen and acknowledges it.
    initial begin
        forever begin
            @(negedge clk);
            if (irq && !irq_ack && exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_eq(t, int'(irq_vec), e);
                irq_ack = 1'b1;
            end else begin
                irq_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset values
        irq_chk("R1", 0);
        rd_chk("R1", 2'd0, 0);
        rd_chk("R1", 2'd1, 'hFF);
        rd_chk("R1", 2'd2, 0);
        rd_chk("R1", 2'd3, 0);

        // Levels: s0=1 s1=1 s2=2 s3=3 s4=0 s5=2 s6=1 s7=3
        wr(2'd2, 'hD8E5);
        rd_chk("R5", 2'd2, 'hD8E5);

        // R2, R4: masked request still latches and stays after input falls
        raise('h04);
        repeat (3) @(posedge clk);
        rd_chk("R2", 2'd0, 'h04);
        drop_all();
        rd_chk("R2", 2'd0, 'h04);
        irq_chk("R4", 0);

        // R3: zero bits leave, one bits clear
        wr(2'd0, 'h00);
        rd_chk("R3", 2'd0, 'h04);
        wr(2'd0, 'h04);
        rd_chk("R3", 2'd0, 'h00);

        // R7: level 0 source unmasked never interrupts
        wr(2'd1, 'h00);
        raise('h10);
        repeat (6) @(posedge clk);
        rd_chk("R7", 2'd0, 'h10);
        irq_chk("R7", 0);
        drop_all();
        wr(2'd0, 'h10);

        // R5, R11: s1 (lvl1) and s3 (lvl3) together, s3 first, irq on 4th edge
        expect_vec(3, "R5");
        raise('h0A);
        repeat (3) @(posedge clk);
        @(negedge clk) check_eq("R11", int'(irq), 0);
        @(posedge clk);
        @(negedge clk) check_eq("R11", int'(irq), 1);
        @(posedge clk);
        @(negedge clk) check_eq("R11", int'(irq), 0);
        drain("R5");
        drop_all();
        rd_chk("R8", 2'd0, 'h02);
        rd_chk("R8", 2'd3, 3);
        irq_chk("R9", 0);
        expect_vec(1, "R10");
        wr(2'd3, 0);
        drain("R10");
        rd_chk("R10", 2'd3, 1);
        wr(2'd3, 0);
        rd_chk("R10", 2'd3, 0);

        // R6: s0 and s6 share level 1, s0 first; then equal level waits
        expect_vec(0, "R6");
        raise('h41);
        drain("R6");
        drop_all();
        irq_chk("R9", 0);
        rd_chk("R6", 2'd0, 'h40);
        expect_vec(6, "R6");
        wr(2'd3, 0);
        drain("R6");
        wr(2'd3, 0);
        rd_chk("R8", 2'd0, 'h00);

        // R9: nested preemption 1 -> 2 -> 7
        expect_vec(1, "R9");
        raise('h02);
        drain("R9");
        drop_all();
        rd_chk("R9", 2'd3, 1);
        expect_vec(2, "R9");
        raise('h04);
        drain("R9");
        drop_all();
        rd_chk("R9", 2'd3, 2);
        expect_vec(7, "R9");
        raise('h80);
        drain("R9");
        drop_all();
        rd_chk("R9", 2'd3, 3);
        wr(2'd3, 0);
        rd_chk("R10", 2'd3, 2);
        irq_chk("R10", 0);
        wr(2'd3, 0);
        rd_chk("R10", 2'd3, 1);
        wr(2'd3, 0);
        rd_chk("R10", 2'd3, 0);
        // R10: pop on empty stack is ignored
        wr(2'd3, 0);
        rd_chk("R10", 2'd3, 0);
        irq_chk("R10", 0);

        // R4: mask holds s5 back; unmasking releases it
        wr(2'd1, 'h20);
        raise('h20);
        repeat (6) @(posedge clk);
        irq_chk("R4", 0);
        rd_chk("R4", 2'd0, 'h20);
        expect_vec(5, "R4");
        wr(2'd1, 'h00);
        drain("R4");
        drop_all();
        rd_chk("R4", 2'd3, 2);
        wr(2'd3, 0);
        rd_chk("R8", 2'd0, 'h00);
        irq_chk("R8", 0);

        summary();
    end
endmodule